// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block connects a fixed set of thirteen internal peripheral signals to an eight-pin bidirectional port. Seven groups of signals are available: serial transmit and receive, two-wire bus data and clock, two comparator outputs, a clock output, four counter-array channels and two timer inputs. Each group has an enable bit. Enabled groups take pins in a fixed priority order, one signal per pin, starting at the lowest pin number. Pins set to analog mode are skipped. Digital pins that no signal claims are driven from a port latch.

Each pin produces three outputs: a drive value, a drive enable and a weak pull-up enable. These go to the pad cell. The value read from each claimed pin goes back to the signal that owns it. All configuration inputs pass through one register stage before they take effect. This keeps the pin map, the pin modes and the pull-ups consistent with each other in every cycle. The peripheral data (`sig_out`), the port latch and the pin readback (`pin_in`, `sig_in`) are combinational through the block.

Top module: `prio_pin_xbar`

## Requirements
- R1: While reset is held and after it is released, until new configuration is loaded: every `drv_en` and `drv_val` bit is 0, every `pu_en` bit is 1, and every `sig_in` bit is 1.
- R2: A change on `xbar_en`, `grp_en`, `ana_sel`, `od_sel` or `pu_dis` is sampled on a rising clock edge and reaches the outputs only after that edge.
- R3: Signal index order is also the priority order. The indices are: 0 serial TX, 1 serial RX, 2 bus data, 3 bus clock, 4 and 5 comparator, 6 clock output, 7 to 10 counter channels, 11 timer 0 input, 12 timer 1 input. The enable bits of `grp_en` are: bit 0 serial, bit 1 bus, bit 2 comparator, bit 3 clock output, bit 4 counter, bit 5 timer 0, bit 6 timer 1. Every signal in an enabled group takes the next free digital pin, scanning upward from pin 0, and each signal holds at most one pin.
- R4: A pin with its `ana_sel` bit set is never claimed. It is never driven, its pull-up is off, and its `pin_in` bit reaches no signal.
- R5: When the enabled signals outnumber the digital pins, the signals lowest in priority get no pin.
- R6: A digital pin that no signal claims carries its `port_latch` bit as its output value.
- R7: In push-pull mode (`od_sel` bit 0), a digital pin with an output source has `drv_en` set to 1 and `drv_val` equal to the source value. `drv_val` is 0 whenever `drv_en` is 0.
- R8: In open-drain mode (`od_sel` bit 1), the pin drives only a low level: `drv_en` is the inverse of the source value and `drv_val` is always 0.
- R9: A pin claimed by an input-only signal (indices 1, 11 and 12) is never driven.
- R10: `pu_en` of a pin is 1 exactly when `pu_dis` is 0, the pin is digital, and the pin is not driving low.
- R11: While `xbar_en` is 0, no pin is driven, no pin is claimed, and every `sig_in` bit reads 1.
- R12: `sig_in` of a claimed signal follows the `pin_in` bit of its pin. An unclaimed signal reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xbar_en | input | 1 | Master enable for the crossbar |
| grp_en | input | 7 | Enable bit for each signal group |
| ana_sel | input | 8 | Per-pin analog mode select |
| od_sel | input | 8 | Per-pin open-drain select |
| pu_dis | input | 1 | Turns off all weak pull-ups |
| port_latch | input | 8 | Output values for unclaimed pins |
| sig_out | input | 13 | Output values from the peripherals, by signal index |
| pin_in | input | 8 | Levels read from the pins |
| sig_in | output | 13 | Pin levels returned to the peripherals, by signal index |
| drv_val | output | 8 | Per-pin output value |
| drv_en | output | 8 | Per-pin output driver enable |
| pu_en | output | 8 | Per-pin weak pull-up enable |

## Verification
The bench tries all 128 group-enable patterns twice: once with every pin digital, and once with two analog pins in the middle of the port. Each pin is probed one at a time so that the pin holding every signal is found. A design that fails to skip analog pins, or that packs groups in the wrong order, moves every later signal one pin away. A design that fails to truncate cleanly drops or duplicates the lowest-priority signals. Directed cases cover the points where a design could quietly misbehave:
- an input-only signal driving its pin;
- open-drain mode driving high;
- a pull-up left on against a low drive;
- readback from an analog pin leaking into a signal;
- configuration taking effect in the same cycle it is applied, which would break the one-edge latency.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam int NGRP = 7;
  localparam int NSIG = 13;
  localparam int SIGW = $clog2(NSIG + 1);
  localparam logic [SIGW-1:0] SIG_NONE = SIGW'(NSIG);
  // signals that only receive from their pin (serial RX, timer inputs)
  localparam logic [NSIG-1:0] IN_ONLY = 13'b1_1000_0000_0010;

  // group owning each signal index; group order is the priority order
  function automatic int grp_of(input int s);
    if (s < 2)       return 0;
    else if (s < 4)  return 1;
    else if (s < 6)  return 2;
    else if (s < 7)  return 3;
    else if (s < 11) return 4;
    else if (s < 12) return 5;
    else             return 6;
  endfunction

  typedef struct packed {
    logic            on;
    logic [NGRP-1:0] grp;
    logic            pu_off;
  } glb_cfg_t;
endpackage

// File: rtl/pxb_alloc.sv
module pxb_alloc
  import pxb_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic                  on,
  input  logic [NGRP-1:0]       grp,
  input  logic [NPINS-1:0]      ana,
  output logic [NPINS*SIGW-1:0] owner
);
  // A signal's ordinal among enabled signals is matched against a pin's
  // ordinal among digital pins.
  function automatic logic [NPINS*SIGW-1:0] build_map(
    input logic on_i, input logic [NGRP-1:0] grp_i, input logic [NPINS-1:0] ana_i);
    logic [NPINS*SIGW-1:0] m;
    logic [NSIG-1:0]       sel;
    int                    ord [NSIG];
    int                    c;
    c = 0;
    for (int s = 0; s < NSIG; s++) begin
      ord[s] = c;
      sel[s] = on_i && grp_i[grp_of(s)];
      if (sel[s]) c++;
    end
    c = 0;
    for (int q = 0; q < NPINS; q++) begin
      m[q*SIGW +: SIGW] = SIG_NONE;
      if (!ana_i[q]) begin
        for (int s = 0; s < NSIG; s++)
          if (sel[s] && ord[s] == c) m[q*SIGW +: SIGW] = SIGW'(s);
        c++;
      end
    end
    return m;
  endfunction

  always_comb owner = build_map(on, grp, ana);
endmodule

// File: rtl/pxb_pin.sv
module pxb_pin
  import pxb_pkg::*;
(
  input  logic            on,
  input  logic            ana,
  input  logic            od,
  input  logic            pu_off,
  input  logic [SIGW-1:0] owner,
  input  logic            latch,
  input  logic [NSIG-1:0] sig_out,
  output logic            drv_en,
  output logic            drv_val,
  output logic            pu_en
);
  logic src_val;
  logic src_drv;
  logic act;

  always_comb begin
    if (owner == SIG_NONE) begin
      src_val = latch;
      src_drv = 1'b1;
    end else begin
      src_val = sig_out[owner];
      src_drv = !IN_ONLY[owner];
    end
    act = on && !ana && src_drv;
    if (od) begin
      drv_en  = act && !src_val;
      drv_val = 1'b0;
    end else begin
      drv_en  = act;
      drv_val = act && src_val;
    end
    pu_en = !pu_off && !ana && !(drv_en && !drv_val);
  end
endmodule

// File: rtl/pxb_route.sv
module pxb_route
  import pxb_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic [NPINS*SIGW-1:0] owner,
  input  logic [NPINS-1:0]      pin_in,
  output logic [NSIG-1:0]       sig_in,
  output logic [NSIG*NPINS-1:0] claim
);
  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    for (genvar q = 0; q < NPINS; q++) begin : g_pin
      assign claim[s*NPINS + q] = (owner[q*SIGW +: SIGW] == SIGW'(s));
    end
    assign sig_in[s] = (|claim[s*NPINS +: NPINS])
                     ? (|(claim[s*NPINS +: NPINS] & pin_in)) : 1'b1;
  end
endmodule

// File: rtl/prio_pin_xbar.sv
module prio_pin_xbar
  import pxb_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xbar_en,
  input  logic [NGRP-1:0]    grp_en,
  input  logic [NPINS-1:0]   ana_sel,
  input  logic [NPINS-1:0]   od_sel,
  input  logic               pu_dis,
  input  logic [NPINS-1:0]   port_latch,
  input  logic [NSIG-1:0]    sig_out,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NSIG-1:0]    sig_in,
  output logic [NPINS-1:0]   drv_val,
  output logic [NPINS-1:0]   drv_en,
  output logic [NPINS-1:0]   pu_en
);
  glb_cfg_t               cfg_q;
  logic [NPINS-1:0]       ana_q;
  logic [NPINS-1:0]       od_q;
  logic [NPINS*SIGW-1:0]  owner;
  logic [NSIG*NPINS-1:0]  claim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ana_q <= '0;
      od_q  <= '0;
    end else begin
      cfg_q <= '{on: xbar_en, grp: grp_en, pu_off: pu_dis};
      ana_q <= ana_sel;
      od_q  <= od_sel;
    end
  end

  pxb_alloc #(.NPINS(NPINS)) u_alloc (
    .on    (cfg_q.on),
    .grp   (cfg_q.grp),
    .ana   (ana_q),
    .owner (owner)
  );

  for (genvar q = 0; q < NPINS; q++) begin : g_pin
    pxb_pin u_pin (
      .on      (cfg_q.on),
      .ana     (ana_q[q]),
      .od      (od_q[q]),
      .pu_off  (cfg_q.pu_off),
      .owner   (owner[q*SIGW +: SIGW]),
      .latch   (port_latch[q]),
      .sig_out (sig_out),
      .drv_en  (drv_en[q]),
      .drv_val (drv_val[q]),
      .pu_en   (pu_en[q])
    );
  end

  pxb_route #(.NPINS(NPINS)) u_route (
    .owner  (owner),
    .pin_in (pin_in),
    .sig_in (sig_in),
    .claim  (claim)
  );
endmodule

// File: rtl/prio_pin_xbar_chk.sv
module prio_pin_xbar_chk
  import pxb_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  xbar_en,
  input logic [NPINS-1:0]      ana_sel,
  input logic [NPINS-1:0]      od_sel,
  input logic                  pu_dis,
  input logic [NPINS-1:0]      drv_val,
  input logic [NPINS-1:0]      drv_en,
  input logic [NPINS-1:0]      pu_en,
  input logic [NSIG*NPINS-1:0] claim
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(xbar_en) |-> drv_en == '0); // R11
  AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(ana_sel) & (drv_en | pu_en)) == '0); // R4
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(od_sel) & drv_val) == '0); // R8
  AST_VAL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_val & ~drv_en) == '0); // R7
  AST_PU_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en & drv_en & ~drv_val) == '0); // R10
  AST_PU_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(pu_dis) |-> pu_en == '0); // R10

  for (genvar s = 0; s < NSIG; s++) begin : g_one
    AST_ONE_PIN_PER_SIG: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(claim[s*NPINS +: NPINS])); // R3
  end
endmodule

bind prio_pin_xbar prio_pin_xbar_chk #(.NPINS(NPINS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .xbar_en (xbar_en),
  .ana_sel (ana_sel),
  .od_sel  (od_sel),
  .pu_dis  (pu_dis),
  .drv_val (drv_val),
  .drv_en  (drv_en),
  .pu_en   (pu_en),
  .claim   (claim)
);

// File: tb/prio_pin_xbar_bench.sv
module prio_pin_xbar_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xbar_en = 1'b0;
  logic [6:0]  grp_en = '0;
  logic [7:0]  ana_sel = '0, od_sel = '0, port_latch = '0, pin_in = '0;
  logic        pu_dis = 1'b0;
  logic [12:0] sig_out = '0;
  logic [12:0] sig_in;
  logic [7:0]  drv_val, drv_en, pu_en;
  int          errs = 0, checks = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  prio_pin_xbar u_prio_pin_xbar (
    .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .grp_en(grp_en),
    .ana_sel(ana_sel), .od_sel(od_sel), .pu_dis(pu_dis),
    .port_latch(port_latch), .sig_out(sig_out), .pin_in(pin_in),
    .sig_in(sig_in), .drv_val(drv_val), .drv_en(drv_en), .pu_en(pu_en)
  );

  localparam int GRP [13] = '{0, 0, 1, 1, 2, 2, 3, 4, 4, 4, 4, 5, 6};

  typedef struct packed {
    logic on; logic [6:0] g; logic [7:0] a; logic [7:0] o; logic pud;
    logic [7:0] lat; logic [12:0] so;
    logic [7:0] e_en; logic [7:0] e_val; logic [7:0] e_pu;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{1'b1, 7'h01, 8'h00, 8'h00, 1'b0, 8'hF0, 13'h0000, 8'hFD, 8'hF0, 8'hF2}, // R6 R7 R9
    '{1'b0, 7'h7F, 8'h0F, 8'h00, 1'b0, 8'hF0, 13'h1FFF, 8'h00, 8'h00, 8'hF0}, // R11
    '{1'b1, 7'h14, 8'h02, 8'hFF, 1'b1, 8'h00, 13'h0310, 8'hCC, 8'h00, 8'h00}, // R4 R8 R10
    '{1'b1, 7'h7F, 8'h00, 8'h00, 1'b0, 8'h00, 13'h1FFF, 8'hFD, 8'hFD, 8'hFF}  // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // sequential walk: pin index of signal s, 8 if none
  function automatic int model_pin(int s, logic on, logic [6:0] g, logic [7:0] a);
    int p = 0;
    for (int t = 0; t <= s; t++) begin
      if (on && g[GRP[t]]) begin
        while (p < 8 && a[p]) p++;
        if (t == s) return (p < 8) ? p : 8;
        if (p < 8) p++;
      end
    end
    return 8;
  endfunction

  task automatic model_out(input logic on, input logic [6:0] g, input logic [7:0] a,
                           input logic [7:0] o, input logic pud, input logic [7:0] lat,
                           input logic [12:0] so, output logic [7:0] e_en,
                           output logic [7:0] e_val, output logic [7:0] e_pu);
    int own [8];
    for (int p = 0; p < 8; p++) own[p] = -1;
    for (int s = 0; s < 13; s++) begin
      int q = model_pin(s, on, g, a);
      if (q < 8) own[q] = s;
    end
    for (int p = 0; p < 8; p++) begin
      logic v, d;
      if (own[p] < 0) begin v = lat[p]; d = 1'b1; end
      else begin
        v = so[own[p]];
        d = !(own[p] == 1 || own[p] == 11 || own[p] == 12);
      end
      d = d && on && !a[p];
      e_en[p]  = o[p] ? (d && !v) : d;
      e_val[p] = o[p] ? 1'b0 : (d && v);
      e_pu[p]  = !pud && !a[p] && !(e_en[p] && !e_val[p]);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] e_en, e_val, e_pu;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 drv_en in reset", 32'(drv_en), 32'h00);
    chk("R1 pu_en in reset", 32'(pu_en), 32'hFF);
    chk("R1 sig_in in reset", 32'(sig_in), 32'h1FFF);
    rst_n = 1'b1;
    step();
    chk("R1 drv_val after reset", 32'(drv_val), 32'h00);
    chk("R1 sig_in after reset", 32'(sig_in), 32'h1FFF);

    // table of hand-worked vectors
    for (int i = 0; i < 4; i++) begin
      xbar_en = VECS[i].on; grp_en = VECS[i].g; ana_sel = VECS[i].a;
      od_sel = VECS[i].o; pu_dis = VECS[i].pud; port_latch = VECS[i].lat;
      sig_out = VECS[i].so;
      step();
      chk("R7/R8 table drv_en", 32'(drv_en), 32'(VECS[i].e_en));
      chk("R6/R7 table drv_val", 32'(drv_val), 32'(VECS[i].e_val));
      chk("R10 table pu_en", 32'(pu_en), 32'(VECS[i].e_pu));
    end

    // R2: latency of one edge
    xbar_en = 1'b0; step();
    xbar_en = 1'b1; grp_en = 7'h01; ana_sel = '0; od_sel = '0; pu_dis = 1'b0;
    port_latch = 8'hFF; sig_out = 13'h0001;
    #1 chk("R2 no effect before edge", 32'(drv_en), 32'h00);
    step();
    chk("R2 effect after edge", 32'(drv_en), 32'hFD);

    // R12 and R4: analog readback ignored, unclaimed reads 1
    ana_sel = 8'h01; step();
    pin_in = 8'h01;
    #1 chk("R12 R4 readback", 32'(sig_in), 32'h1FFC);
    pin_in = 8'hFE;
    #1 chk("R12 claimed high", 32'(sig_in), 32'h1FFF);

    // R11: readback while off
    xbar_en = 1'b0; step();
    pin_in = 8'h00;
    #1 chk("R11 sig_in while off", 32'(sig_in), 32'h1FFF);

    // sweep of all enable patterns: R3 R5 R6 R7 R8 R12
    xbar_en = 1'b1; port_latch = 8'h96; sig_out = 13'h1A5B;
    for (int pass = 0; pass < 2; pass++) begin
      ana_sel = pass ? 8'h24 : 8'h00;
      od_sel  = pass ? 8'h5A : 8'h00;
      for (int g = 0; g < 128; g++) begin
        int bad;
        int act_pin [13];
        grp_en = 7'(g);
        pin_in = 8'hFF;
        step();
        model_out(1'b1, 7'(g), ana_sel, od_sel, 1'b0, port_latch, sig_out, e_en, e_val, e_pu);
        chk("R3 R6 R7 R8 sweep outputs", {8'h0, drv_en, drv_val, pu_en}, {8'h0, e_en, e_val, e_pu});
        for (int s = 0; s < 13; s++) act_pin[s] = 8;
        for (int p = 0; p < 8; p++) begin
          pin_in = ~(8'h01 << p);
          #1;
          for (int s = 0; s < 13; s++) if (!sig_in[s]) act_pin[s] = p;
        end
        bad = -1;
        for (int s = 0; s < 13; s++)
          if (bad < 0 && act_pin[s] != model_pin(s, 1'b1, 7'(g), ana_sel)) bad = s;
        if (bad < 0) chk("R3 R5 R12 pin map", 32'h0, 32'h0);
        else chk($sformatf("R3 R5 R12 pin of signal %0d grp %0h", bad, g),
                 32'(act_pin[bad]), 32'(model_pin(bad, 1'b1, 7'(g), ana_sel)));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule